// File: doc/BRIEF.md
# Parallel Pulse-Coded LED Strand Driver

This block drives up to sixteen LED strands at once from one shared frame buffer of words. Each strand uses a single-wire code. Every bit lasts three equal phases. In the first phase the line is high. In the second it carries the data bit. In the third it is low. With the default 48 MHz clock and 20-cycle phases, one bit takes 1250 ns. Every pin changes in the same clock, so one frame reaches all strands in the time one strand would need.

The buffer holds bit-planes. Each word carries one bit for every active strand. With S strands the buffer is walked several times, and each walk is called a pass. Pass p gives strand s the word bit p*S+s. A strand's logical stream therefore runs through every address of the buffer in pass 0, then again in pass 1, and so on. LEDs are stored in red, green, blue order, eight words per colour with the most significant bit first. The block sends them green first, then red, then blue. After the last bit it holds every pin low for a latch interval, which tells the strands to show the new colours.

The host configures a frame with a strand count and a per-strand LED count. A one-cycle start pulse begins the frame, and a busy flag reports it until the latch interval has ended.

Top module: `ledstrand_driver`

## Requirements
- R1: After reset, and at any time while idle, busy is 0 and all pins are 0.
- R2: Each bit takes three consecutive phases of PHASE_CYC cycles each. During the first phase every active pin is 1, and during the third phase every active pin is 0.
- R3: Logical bit k of a strand (k counting from 0 in stored order) is read from address k mod DEPTH and pass k div DEPTH. In that pass, pin s carries word bit pass*S+s. The configured length must fit within floor(WORD_W/S) passes.
- R4: LED j occupies stored offsets j*24..j*24+23. Red is at offsets 0..7, green at 8..15 and blue at 16..23, with the MSB at the lowest offset of each colour. The block transmits green, then red, then blue, MSB first, during the second phase of each bit.
- R5: Pins with index at or above the active strand count stay 0 at all times.
- R6: After the last bit, all pins are 0 for exactly LATCH_CYC cycles while busy stays 1. Busy then falls.
- R7: While busy, the start input and any change to the strand count or LED count have no effect on the frame in progress.
- R8: A start is ignored, and the block stays idle, if the LED count is 0 or the strand count is outside 1..WORD_W.
- R9: Busy rises in the clock edge that samples an accepted start. The first bit begins in that same edge. The frame lasts exactly 72*N*PHASE_CYC + LATCH_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to send a frame |
| n_strands | input | $clog2(WORD_W+1) | Active strand count, 1..WORD_W |
| led_count | input | LW | LEDs per strand |
| buf_addr | output | $clog2(DEPTH) | Frame buffer read address |
| buf_data | input | WORD_W | Frame buffer word at buf_addr, combinational read |
| pins | output | WORD_W | Strand data lines |
| busy | output | 1 | Frame or latch interval in progress |

## Verification
A wrong pass, address or colour-slot state shows up as a wrong data phase on the pins. It appears within the bit where it goes wrong, PHASE_CYC cycles after that bit starts. A phase counter that drifts moves every later edge, so the first bad cycle is caught within one bit. A frame-length or latch-count fault shows on busy and on the low pins at the end of the frame. The bench predicts every pin and busy on every cycle from the stored words, and it uses strand counts and lengths that make the stream cross buffer passes and LED boundaries in the middle of a colour.

// File: rtl/ledd_pkg.sv
package ledd_pkg;
   typedef enum logic [1:0] {PH_HIGH = 2'd0, PH_DATA = 2'd1, PH_LOW = 2'd2} phase_e;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SEND = 2'd1, ST_LATCH = 2'd2} state_e;
   localparam int BITS_PER_LED = 24;
   localparam int BITS_PER_COLOUR = 8;
endpackage

// File: rtl/ledd_bitclock.sv
module ledd_bitclock
   import ledd_pkg::*;
#(
   parameter int PHASE_CYC = 20
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clr,
   input  logic   en,
   output phase_e phase,
   output logic   bit_end
);
   localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

   logic [CW-1:0] cnt_q;
   phase_e        ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ph_q  <= PH_HIGH;
      end else if (clr) begin
         cnt_q <= '0;
         ph_q  <= PH_HIGH;
      end else if (en) begin
         if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            unique case (ph_q)
               PH_HIGH: ph_q <= PH_DATA;
               PH_DATA: ph_q <= PH_LOW;
               default: ph_q <= PH_HIGH;
            endcase
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign phase   = ph_q;
   assign bit_end = en && (ph_q == PH_LOW) && (cnt_q == CNT_LAST);

   // R2: a phase only ever advances after its full count of cycles
   assert_phase_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && !$past(clr) && (ph_q != $past(ph_q))) |-> ($past(cnt_q) == CNT_LAST));
   // R2: the data phase is always entered from the high phase
   assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_q == PH_DATA) && ($past(ph_q) != PH_DATA)) |-> ($past(ph_q) == PH_HIGH));
endmodule

// File: rtl/ledd_addrgen.sv
module ledd_addrgen
   import ledd_pkg::*;
#(
   parameter int DEPTH = 625,
   parameter int LW    = 16,
   parameter int PW    = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     step,
   input  logic [LW-1:0]            led_len,
   output logic [$clog2(DEPTH)-1:0] addr,
   output logic [PW-1:0]            pass,
   output logic                     last_bit
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
   localparam logic [AW:0] LED_V   = (AW+1)'(BITS_PER_LED);

   logic [4:0]    slot_q;
   logic [LW-1:0] led_q;
   logic [AW-1:0] base_q;
   logic [PW-1:0] bpass_q;
   logic [4:0]    off;
   logic [AW:0]   sum, nbase;

   // stored colour order red, green, blue; sent green, red, blue
   always_comb begin
      if (slot_q < 5'd8)       off = slot_q + 5'd8;
      else if (slot_q < 5'd16) off = slot_q - 5'd8;
      else                     off = slot_q;
      sum   = (AW+1)'(base_q) + (AW+1)'(off);
      nbase = (AW+1)'(base_q) + LED_V;
      if (sum >= DEPTH_V) begin
         addr = AW'(sum - DEPTH_V);
         pass = bpass_q + 1'b1;
      end else begin
         addr = AW'(sum);
         pass = bpass_q;
      end
   end

   assign last_bit = (slot_q == 5'd23) && (led_q == led_len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q  <= '0;
         led_q   <= '0;
         base_q  <= '0;
         bpass_q <= '0;
      end else if (clr) begin
         slot_q  <= '0;
         led_q   <= '0;
         base_q  <= '0;
         bpass_q <= '0;
      end else if (step) begin
         if (slot_q == 5'd23) begin
            slot_q <= '0;
            led_q  <= led_q + 1'b1;
            if (nbase >= DEPTH_V) begin
               base_q  <= AW'(nbase - DEPTH_V);
               bpass_q <= bpass_q + 1'b1;
            end else begin
               base_q  <= AW'(nbase);
            end
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   // R3: the read address never leaves the buffer
   assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      addr < AW'(DEPTH));
   // R4: the slot moves by one per bit and wraps only after the blue LSB
   assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr) |=> (slot_q == (($past(slot_q) == 5'd23) ? 5'd0 : $past(slot_q) + 5'd1)));
endmodule

// File: rtl/ledd_lanes.sv
module ledd_lanes
   import ledd_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int PW     = 5,
   parameter int SW     = 5
) (
   input  logic              active,
   input  phase_e            phase,
   input  logic [WORD_W-1:0] word,
   input  logic [PW-1:0]     pass,
   input  logic [SW-1:0]     n_str,
   output logic [WORD_W-1:0] pins
);
   localparam int SHW = PW + SW;

   logic [SHW-1:0]    shamt;
   logic [WORD_W-1:0] plane;

   assign shamt = SHW'(pass) * SHW'(n_str);
   assign plane = word >> shamt;

   for (genvar s = 0; s < WORD_W; s++) begin : g_pin
      logic lane_on;
      assign lane_on = active && (SW'(s) < n_str);
      always_comb begin
         unique case (phase)
            PH_HIGH: pins[s] = lane_on;
            PH_DATA: pins[s] = lane_on & plane[s];
            default: pins[s] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/ledstrand_driver.sv
module ledstrand_driver
   import ledd_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int DEPTH     = 625,
   parameter int PHASE_CYC = 20,
   parameter int LATCH_CYC = 2400,
   parameter int LW        = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [$clog2(WORD_W+1)-1:0]  n_strands,
   input  logic [LW-1:0]                led_count,
   output logic [$clog2(DEPTH)-1:0]     buf_addr,
   input  logic [WORD_W-1:0]            buf_data,
   output logic [WORD_W-1:0]            pins,
   output logic                         busy
);
   localparam int SW  = $clog2(WORD_W + 1);
   localparam int PW  = SW;
   localparam int LCW = (LATCH_CYC > 1) ? $clog2(LATCH_CYC) : 1;
   localparam logic [SW-1:0] MAX_STR = SW'(WORD_W);

   if (DEPTH < BITS_PER_LED) begin : g_bad_depth
      $error("DEPTH must hold at least one LED");
   end
   if (PHASE_CYC < 1 || LATCH_CYC < 1) begin : g_bad_timing
      $error("phase and latch lengths must be positive");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("WORD_W must be positive");
   end

   state_e         st_q;
   logic [SW-1:0]  str_q;
   logic [LW-1:0]  len_q;
   logic [LCW-1:0] lat_q;
   logic           accept, sending, bit_end, last_bit;
   phase_e         phase;
   logic [PW-1:0]  pass;

   assign accept  = (st_q == ST_IDLE) && start && (led_count != '0)
                    && (n_strands != '0) && (n_strands <= MAX_STR);
   assign sending = (st_q == ST_SEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         str_q <= '0;
         len_q <= '0;
         lat_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept) begin
               st_q  <= ST_SEND;
               str_q <= n_strands;
               len_q <= led_count;
            end
            ST_SEND: if (bit_end && last_bit) begin
               st_q  <= ST_LATCH;
               lat_q <= '0;
            end
            default: begin
               if (lat_q == LCW'(LATCH_CYC - 1)) st_q <= ST_IDLE;
               else lat_q <= lat_q + 1'b1;
            end
         endcase
      end
   end

   ledd_bitclock #(.PHASE_CYC(PHASE_CYC)) u_clk (
      .clk(clk), .rst_n(rst_n), .clr(accept), .en(sending),
      .phase(phase), .bit_end(bit_end)
   );

   ledd_addrgen #(.DEPTH(DEPTH), .LW(LW), .PW(PW)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(accept), .step(bit_end),
      .led_len(len_q), .addr(buf_addr), .pass(pass), .last_bit(last_bit)
   );

   ledd_lanes #(.WORD_W(WORD_W), .PW(PW), .SW(SW)) u_lanes (
      .active(sending), .phase(phase), .word(buf_data),
      .pass(pass), .n_str(str_q), .pins(pins)
   );

   assign busy = (st_q != ST_IDLE);

   // R1: nothing is driven while idle
   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pins == '0));
   // R6: the latch interval keeps every line low
   assert_latch_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LATCH) |-> (pins == '0));
   // R5: lines above the active count never rise
   assert_high_pins_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((pins >> str_q) == '0));
   // R7: the frame configuration is frozen while a frame runs
   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(str_q) && $stable(len_q)));
   // R3: the active pass stays inside the word
   assert_pass_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sending |-> ((int'(pass) + 1) * int'(str_q) <= WORD_W));
endmodule

// File: tb/tb_ledstrand_driver.sv
module tb_ledstrand_driver;
   localparam int CLK_PERIOD = 10;
   localparam int WORD_W = 16;
   localparam int DEPTH  = 30;
   localparam int PH     = 2;
   localparam int LAT    = 12;
   localparam int LW     = 16;
   localparam int SW     = $clog2(WORD_W + 1);
   localparam int AW     = $clog2(DEPTH);

   logic              clk = 0;
   logic              rst_n = 0;
   logic              start = 0;
   logic [SW-1:0]     n_strands = '0;
   logic [LW-1:0]     led_count = '0;
   logic [AW-1:0]     buf_addr;
   logic [WORD_W-1:0] buf_data;
   logic [WORD_W-1:0] pins;
   logic              busy;
   logic [WORD_W-1:0] mem [DEPTH];

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign buf_data = mem[buf_addr];

   ledstrand_driver #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PHASE_CYC(PH),
                      .LATCH_CYC(LAT), .LW(LW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .n_strands(n_strands),
      .led_count(led_count), .buf_addr(buf_addr), .buf_data(buf_data),
      .pins(pins), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural expectation for cycle k after the accepting edge
   function automatic logic [WORD_W-1:0] exp_pins(input int k, input int s_cnt, input int n_led);
      logic [WORD_W-1:0] v = '0;
      int p3 = 3 * PH;
      int nb = 24 * n_led * p3;
      if (k >= nb) return '0;
      begin
         int t = k / p3;
         int ph = (k % p3) / PH;
         int w = t % 24;
         int off = (w < 8) ? w + 8 : ((w < 16) ? w - 8 : w);
         int idx = (t / 24) * 24 + off;
         int ps = idx / DEPTH;
         int a = idx % DEPTH;
         for (int s = 0; s < s_cnt; s++) begin
            if (ph == 0) v[s] = 1'b1;
            else if (ph == 1) v[s] = mem[a][ps * s_cnt + s];
         end
      end
      return v;
   endfunction

   task automatic run_frame(input int s_cnt, input int n_led, input bit poke);
      int total = 72 * n_led * PH + LAT;
      int nb = 72 * n_led * PH;
      @(negedge clk);
      n_strands = SW'(s_cnt);
      led_count = LW'(n_led);
      start = 1;
      @(negedge clk);
      start = 0;
      for (int k = 0; k <= total; k++) begin
         logic [WORD_W-1:0] e = exp_pins(k, s_cnt, n_led);
         logic [WORD_W-1:0] lo_mask = (s_cnt >= WORD_W) ? '0 : ~((WORD_W'(1) << s_cnt) - 1'b1);
         if (k >= nb)
            chk(pins == '0, "R6 latch low", pins, 0);
         else if (((k % (3*PH)) / PH) == 1)
            chk((pins & ~lo_mask) == e, "R3,R4 data phase", pins, e);
         else
            chk((pins & ~lo_mask) == e, "R2 high/low phase", pins, e);
         chk((pins & lo_mask) == '0, "R5 unused pins", pins & lo_mask, 0);
         chk(busy == (k < total), "R9 busy window", busy, k < total);
         if (poke && k == 7) begin
            start = 1;                      // R7: ignored while busy
            n_strands = SW'((s_cnt % WORD_W) + 1);
            led_count = LW'(n_led + 1);
         end
         if (poke && k == 8) start = 0;
         @(negedge clk);
      end
      n_strands = SW'(s_cnt);
      led_count = LW'(n_led);
   endtask

   task automatic try_reject(input int s_cnt, input int n_led, input string req);
      @(negedge clk);
      n_strands = SW'(s_cnt);
      led_count = LW'(n_led);
      start = 1;
      @(negedge clk);
      start = 0;
      for (int k = 0; k < 4; k++) begin
         chk(!busy && pins == '0, req, {busy, pins}, 0);
         @(negedge clk);
      end
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++)
         mem[i] = WORD_W'(i * 40503 + 12345) ^ WORD_W'(i << 7);
      fork
         begin
            repeat (3) @(negedge clk);
            chk(busy == 0 && pins == '0, "R1 in reset", {busy, pins}, 0);
            rst_n = 1;
            @(negedge clk);
            chk(busy == 0 && pins == '0, "R1 idle after reset", {busy, pins}, 0);
            run_frame(3, 3, 1'b0);
            run_frame(1, 5, 1'b1);
            run_frame(16, 1, 1'b0);
            run_frame(5, 3, 1'b1);
            run_frame(7, 2, 1'b0);
            try_reject(4, 0, "R8 zero length");
            try_reject(0, 2, "R8 zero strands");
            try_reject(17, 2, "R8 too many strands");
            run_frame(2, 2, 1'b0);
         end
         begin
            repeat (150000) @(posedge clk);
            chk(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule